// File: doc/BRIEF.md
# 8-bit Timer/Counter with Output Compare and Waveform Generator

This block is an 8-bit up/down counter with a single compare channel. A clock-source select chooses what advances the count. The choices are nothing at all, a tick derived from the system clock through a divide-select prescaler, or a tick that arrives already synchronized from an external slow oscillator. On every timer tick the current count is compared with the active compare value. A hit raises a sticky compare flag and drives a waveform generator. A wrap of the counter raises a sticky overflow flag. Each flag can request an interrupt through its own mask bit.

The compare value is double-buffered. Software writes the buffer, and the waveform mode decides when the buffer reaches the active register. There are four modes. In free-running mode the counter wraps at 0xFF. In clear-on-compare mode the compare value acts as the TOP of the count. Fast PWM sets the output at the wrap. Phase-correct PWM counts up to 0xFF and back down to 0x00. Registers are reached over a plain single-cycle write/read bus with a combinational read path.

Top module: `tmr8_oc`

## Requirements
- R1: Register map by bus address: 0 = control, 1 = count, 2 = compare (reads return the buffer), 3 = flags. The flags register holds the compare flag in bit 0, the overflow flag in bit 1, the compare mask in bit 4 and the overflow mask in bit 5. After reset every register, `wave_out` and `irq` are 0.
- R2: Control bits [1:0] select the count source: 0 or 3 stops the count, 1 selects the prescaled system clock, 2 selects `ext_tick`. While the count is stopped it holds its value, and `ext_tick` pulses have no effect.
- R3: With source 1, control bits [3:2] = d give exactly one count per 4^d system clock cycles.
- R4: With source 2, each cycle with `ext_tick` high advances the count by one.
- R5: Control bits [5:4] select the mode: 0 free-running, 1 clear-on-compare, 2 fast PWM, 3 phase-correct PWM. In free-running mode the count goes from 0xFF to 0x00 and sets the overflow flag.
- R6: A tick that finds the count equal to the active compare value sets the compare flag, and the flag stays set until it is cleared. A bus write to the count suppresses the compare match on the next tick.
- R7: Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged. Every write to address 3 loads both mask bits. `irq` is high when any flag is set together with its mask bit.
- R8: In clear-on-compare mode, a tick at the compare value returns the count to 0x00. In free-running and clear-on-compare modes every compare match toggles `wave_out`.
- R9: In free-running and clear-on-compare modes a compare write takes effect at once. In fast PWM it takes effect on the tick at 0xFF. In phase-correct mode it takes effect on the tick at 0xFF or at 0x00.
- R10: In fast PWM with compare value c, `wave_out` is high for c+1 of every 256 ticks.
- R11: Phase-correct mode counts 0x00 up to 0xFF and back down, so one period is 510 ticks. Reaching 0x00 on the way down sets the overflow flag. With compare value c, `wave_out` is high for 2*c of every 510 ticks: 0 ticks when c = 0 and all 510 ticks when c = 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_tick | input | 1 | Synchronized tick from the external oscillator |
| wave_out | output | 1 | Waveform generator output |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest case to reach from the ports is the interval between writing a new compare value in a PWM mode and the update point that makes it active. During that interval the old value must still produce matches. The bench drives `ext_tick` as a single-step clock, so it can place the count exactly: it shows a match at the old value, steps through the wrap, and then shows that only the new value matches. The duty-cycle sweeps over many compare values in both PWM modes include the extreme values 0x00 and 0xFF, where the set and clear events fall on the same tick.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_CTC    = 2'd1,
    MD_FAST   = 2'd2,
    MD_PHASE  = 2'd3
  } tmr_mode_e;

  localparam logic [1:0] CS_OFF  = 2'd0;
  localparam logic [1:0] CS_PRE  = 2'd1;
  localparam logic [1:0] CS_EXT  = 2'd2;
  localparam logic [1:0] CS_OFF2 = 2'd3;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_CNT  = 2'd1;
  localparam logic [1:0] ADR_CMP  = 2'd2;
  localparam logic [1:0] ADR_FLAG = 2'd3;

endpackage

// File: rtl/tmr8_clksel.sv
module tmr8_clksel
  import tmr8_pkg::*;
#(
  parameter int DIV_STEP = 2,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [1:0]       src_sel,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             ext_tick,
  output logic             tick
);

  localparam int PRE_W = DIV_STEP * ((1 << SEL_W) - 1);

  logic [PRE_W-1:0] pre_q, pre_d, div_mask;
  logic             pre_tick;

  // Low bits of the free-running prescaler that must all be ones for a tick
  always_comb begin
    pre_d = pre_q + 1'b1;
    for (int i = 0; i < PRE_W; i++) begin
      div_mask[i] = (i < DIV_STEP * int'(div_sel));
    end
    pre_tick = &(pre_q | ~div_mask);
    case (src_sel)
      CS_PRE:  tick = pre_tick;
      CS_EXT:  tick = ext_tick;
      default: tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

endmodule

// File: rtl/tmr8_count.sv
module tmr8_count
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  tmr_mode_e    mode,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt_o,
  output logic         down_o,
  output logic         ovf_o
);

  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    if (load) begin
      cnt_d = load_val;
    end else if (tick) begin
      case (mode)
        MD_CTC:  cnt_d = (cnt_q == top_val) ? '0 : cnt_q + 1'b1;
        MD_PHASE: begin
          if (!down_q) begin
            if (cnt_q == CNT_MAX) begin
              cnt_d  = cnt_q - 1'b1;
              down_d = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_d  = CNT_ONE;
              down_d = 1'b0;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: cnt_d = cnt_q + 1'b1;
      endcase
    end
    if (mode != MD_PHASE) down_d = 1'b0;
    ovf_o = tick & ~load &
            ((mode == MD_PHASE) ? (down_q && cnt_q == CNT_ONE) : (cnt_q == CNT_MAX));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign down_o = down_q;

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         step,
  input  logic         match,
  input  tmr_mode_e    mode,
  input  logic [W-1:0] cnt,
  input  logic         down,
  input  logic [W-1:0] cmp,
  output logic         wave_o
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic wave_q, wave_d;

  always_comb begin
    wave_d = wave_q;
    case (mode)
      MD_FAST: begin
        if (step && cnt == CNT_MAX) wave_d = 1'b1;
        else if (match)             wave_d = 1'b0;
      end
      MD_PHASE: begin
        // Extreme compare values pin the output for the whole period
        if (step && cnt == CNT_MAX && cmp == CNT_MAX)      wave_d = 1'b1;
        else if (step && cnt == '0 && down && cmp == '0)   wave_d = 1'b0;
        else if (match)                                    wave_d = down;
      end
      default: begin
        if (match) wave_d = ~wave_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_d;
  end

  assign wave_o = wave_q;

endmodule

// File: rtl/tmr8_oc.sv
module tmr8_oc
  import tmr8_pkg::*;
#(
  parameter int W        = 8,
  parameter int DIV_STEP = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         ext_tick,
  output logic         wave_out,
  output logic         irq
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [1:0]   rs_q;
  logic         rst_sn;
  logic [5:0]   ctrl_q, ctrl_d;
  tmr_mode_e    mode;
  logic         ctrl_wr, cnt_wr, cmp_wr, flag_wr;
  logic         tick, step, match, upd_pt;
  logic [W-1:0] cnt_q;
  logic         dir_down, ovf_evt;
  logic [W-1:0] cmp_buf_q, cmp_buf_d, cmp_act_q, cmp_act_d;
  logic         blk_q, blk_d;
  logic         cf_q, cf_d, of_q, of_d, cm_q, cm_d, om_q, om_d;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  assign mode = tmr_mode_e'(ctrl_q[5:4]);

  always_comb begin
    ctrl_wr = bus_we && (bus_addr == ADR_CTRL);
    cnt_wr  = bus_we && (bus_addr == ADR_CNT);
    cmp_wr  = bus_we && (bus_addr == ADR_CMP);
    flag_wr = bus_we && (bus_addr == ADR_FLAG);
  end

  tmr8_clksel #(.DIV_STEP(DIV_STEP), .SEL_W(2)) u_clksel (
    .clk      (clk),
    .rst_ni   (rst_sn),
    .src_sel  (ctrl_q[1:0]),
    .div_sel  (ctrl_q[3:2]),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  tmr8_count #(.W(W)) u_count (
    .clk      (clk),
    .rst_ni   (rst_sn),
    .tick     (tick),
    .load     (cnt_wr),
    .load_val (bus_wdata),
    .mode     (mode),
    .top_val  (cmp_act_q),
    .cnt_o    (cnt_q),
    .down_o   (dir_down),
    .ovf_o    (ovf_evt)
  );

  assign step  = tick & ~cnt_wr;
  assign match = step & ~blk_q & (cnt_q == cmp_act_q);

  tmr8_wave #(.W(W)) u_wave (
    .clk    (clk),
    .rst_ni (rst_sn),
    .step   (step),
    .match  (match),
    .mode   (mode),
    .cnt    (cnt_q),
    .down   (dir_down),
    .cmp    (cmp_act_q),
    .wave_o (wave_out)
  );

  always_comb begin
    ctrl_d    = ctrl_wr ? bus_wdata[5:0] : ctrl_q;
    cmp_buf_d = cmp_wr ? bus_wdata : cmp_buf_q;
    case (mode)
      MD_FAST:  upd_pt = step && (cnt_q == CNT_MAX);
      MD_PHASE: upd_pt = step && ((cnt_q == CNT_MAX) || (cnt_q == '0));
      default:  upd_pt = 1'b0;
    endcase
    cmp_act_d = cmp_act_q;
    if (cmp_wr && (mode == MD_NORMAL || mode == MD_CTC)) cmp_act_d = bus_wdata;
    else if (upd_pt)                                     cmp_act_d = cmp_buf_q;
    blk_d = cnt_wr ? 1'b1 : (tick ? 1'b0 : blk_q);
    cf_d = cf_q;
    if (flag_wr && bus_wdata[0]) cf_d = 1'b0;
    if (match)                   cf_d = 1'b1;
    of_d = of_q;
    if (flag_wr && bus_wdata[1]) of_d = 1'b0;
    if (ovf_evt)                 of_d = 1'b1;
    cm_d = flag_wr ? bus_wdata[4] : cm_q;
    om_d = flag_wr ? bus_wdata[5] : om_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q    <= '0;
      cmp_buf_q <= '0;
      cmp_act_q <= '0;
      blk_q     <= 1'b0;
      cf_q      <= 1'b0;
      of_q      <= 1'b0;
      cm_q      <= 1'b0;
      om_q      <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      cmp_buf_q <= cmp_buf_d;
      cmp_act_q <= cmp_act_d;
      blk_q     <= blk_d;
      cf_q      <= cf_d;
      of_q      <= of_d;
      cm_q      <= cm_d;
      om_q      <= om_d;
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_CTRL: bus_rdata = W'(ctrl_q);
      ADR_CNT:  bus_rdata = cnt_q;
      ADR_CMP:  bus_rdata = cmp_buf_q;
      default:  bus_rdata = W'({om_q, cm_q, 2'b00, of_q, cf_q});
    endcase
  end

  assign irq = (cf_q & cm_q) | (of_q & om_q);

endmodule

// File: rtl/tmr8_oc_chk.sv
module tmr8_oc_chk
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_sn,
  input logic [5:0]   ctrl,
  input logic [W-1:0] cnt,
  input logic [W-1:0] act,
  input logic         tick,
  input logic         cnt_wr,
  input logic         flag_wr,
  input logic [W-1:0] wdata,
  input logic         dir_down,
  input logic         cf,
  input logic         of,
  input logic         cm,
  input logic         om,
  input logic         irq
);

  localparam logic [W-1:0] CNT_MAX = '1;

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    ((ctrl[1:0] == CS_OFF || ctrl[1:0] == CS_OFF2) && !cnt_wr) |=> $stable(cnt)); // R2

  AST_NORMAL_WRAP: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctrl[5:4] == MD_NORMAL && tick && !cnt_wr && cnt == CNT_MAX) |=> (cnt == '0 && of)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    (cf && !(flag_wr && wdata[0])) |=> cf); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cm && !om) |-> !irq); // R7

  AST_CTC_RESTART: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctrl[5:4] == MD_CTC && tick && !cnt_wr && cnt == act) |=> (cnt == '0)); // R8

  AST_FAST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctrl[5:4] == MD_FAST && !(tick && !cnt_wr && cnt == CNT_MAX)) |=> $stable(act)); // R9

  AST_PHASE_TURN: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctrl[5:4] == MD_PHASE && tick && !cnt_wr && cnt == CNT_MAX && !dir_down)
      |=> (dir_down && cnt == CNT_MAX - 1'b1)); // R11

endmodule

bind tmr8_oc tmr8_oc_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .ctrl     (ctrl_q),
  .cnt      (cnt_q),
  .act      (cmp_act_q),
  .tick     (tick),
  .cnt_wr   (cnt_wr),
  .flag_wr  (flag_wr),
  .wdata    (bus_wdata),
  .dir_down (dir_down),
  .cf       (cf_q),
  .of       (of_q),
  .cm       (cm_q),
  .om       (om_q),
  .irq      (irq)
);

// File: tb/tmr8_oc_tb.sv
module tmr8_oc_tb;

  logic       clk;
  logic       rst_n;
  logic       bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       ext_tick;
  logic       wave_out;
  logic       irq;

  int n_chk;
  int n_bad;
  bit done;

  tmr8_oc u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_tick  (ext_tick),
    .wave_out  (wave_out),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ext_tick = 1'b1;
      @(negedge clk);
      ext_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, a, b;
    int hi;
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'd0; ext_tick = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      chk("R1 reset reg", int'(v), 0);
    end
    chk("R1 reset wave", int'(wave_out), 0);
    chk("R1 reset irq", int'(irq), 0);

    // R2 stopped source holds the count, ext ticks ignored
    wr(2'd1, 8'h40);
    pulse(10);
    rd(2'd1, v); chk("R2 stop src0", int'(v), 8'h40);
    repeat (50) @(negedge clk);
    rd(2'd1, v); chk("R2 stop hold", int'(v), 8'h40);
    wr(2'd0, 8'h03);
    pulse(5);
    rd(2'd1, v); chk("R2 stop src3", int'(v), 8'h40);

    // R3 prescaler divide select
    for (int d = 0; d < 4; d++) begin
      wr(2'd0, 8'((d << 2) | 1));
      rd(2'd1, a);
      repeat (192) @(negedge clk);
      rd(2'd1, b);
      chk("R3 prescale count", int'(8'(b - a)), 192 >> (2 * d));
    end

    // R4 external tick source
    wr(2'd0, 8'h02);
    rd(2'd1, a);
    pulse(37);
    rd(2'd1, b); chk("R4 ext count", int'(8'(b - a)), 37);
    repeat (30) @(negedge clk);
    rd(2'd1, v); chk("R4 ext idle", int'(v), int'(b));

    // R5 wrap and overflow flag, R7 mask and clear
    wr(2'd1, 8'hFD);
    wr(2'd3, 8'h03);
    pulse(2);
    rd(2'd3, v); chk("R5 ovf before wrap", int'(v[1]), 0);
    pulse(1);
    rd(2'd3, v); chk("R5 ovf at wrap", int'(v[1]), 1);
    rd(2'd1, v); chk("R5 count wrapped", int'(v), 0);
    chk("R7 irq masked", int'(irq), 0);
    wr(2'd3, 8'h20);
    chk("R7 irq ovf unmasked", int'(irq), 1);
    wr(2'd3, 8'h22);
    rd(2'd3, v); chk("R7 ovf cleared", int'(v), 8'h20);
    chk("R7 irq after clear", int'(irq), 0);

    // R6 compare flag and count-write blocking
    wr(2'd2, 8'h10);
    wr(2'd3, 8'h13);
    wr(2'd1, 8'h0E);
    pulse(2);
    rd(2'd3, v); chk("R6 no match yet", int'(v[0]), 0);
    chk("R7 irq idle", int'(irq), 0);
    pulse(1);
    rd(2'd3, v); chk("R6 match flag", int'(v[0]), 1);
    chk("R7 irq compare", int'(irq), 1);
    wr(2'd3, 8'h13);
    wr(2'd1, 8'h10);
    pulse(1);
    rd(2'd3, v); chk("R6 blocked match", int'(v[0]), 0);
    rd(2'd1, v); chk("R6 count after block", int'(v), 8'h11);
    wr(2'd1, 8'h0F);
    pulse(2);
    rd(2'd3, v); chk("R6 match after block", int'(v[0]), 1);

    // R8 clear-on-compare
    wr(2'd0, 8'h12);
    wr(2'd2, 8'h05);
    wr(2'd3, 8'h03);
    wr(2'd1, 8'h00);
    hi = int'(wave_out);
    pulse(5);
    rd(2'd1, v); chk("R8 ctc count5", int'(v), 5);
    rd(2'd3, v); chk("R8 ctc no flag", int'(v[0]), 0);
    pulse(1);
    rd(2'd1, v); chk("R8 ctc restart", int'(v), 0);
    rd(2'd3, v); chk("R8 ctc flag", int'(v[0]), 1);
    chk("R8 wave toggled", int'(wave_out), hi ^ 1);
    pulse(6);
    rd(2'd1, v); chk("R8 ctc restart2", int'(v), 0);
    chk("R8 wave toggled back", int'(wave_out), hi);

    // R9 double buffer in fast PWM
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h30);
    wr(2'd0, 8'h22);
    wr(2'd2, 8'h90);
    rd(2'd2, v); chk("R9 buffer readback", int'(v), 8'h90);
    wr(2'd3, 8'h03);
    wr(2'd1, 8'h2E);
    pulse(3);
    rd(2'd3, v); chk("R9 old value active", int'(v[0]), 1);
    pulse(207);
    rd(2'd1, v); chk("R9 wrapped", int'(v), 0);
    wr(2'd3, 8'h03);
    pulse(49);
    rd(2'd3, v); chk("R9 old value retired", int'(v[0]), 0);
    pulse(96);
    rd(2'd3, v); chk("R9 new value active", int'(v[0]), 1);

    // R11 phase-correct turn and bottom overflow
    wr(2'd0, 8'h32);
    wr(2'd1, 8'hFE);
    wr(2'd3, 8'h03);
    pulse(2);
    rd(2'd1, v); chk("R11 turned down", int'(v), 8'hFE);
    pulse(253);
    rd(2'd1, v); chk("R11 count near bottom", int'(v), 1);
    rd(2'd3, v); chk("R11 no ovf yet", int'(v[1]), 0);
    pulse(1);
    rd(2'd1, v); chk("R11 bottom", int'(v), 0);
    rd(2'd3, v); chk("R11 ovf at bottom", int'(v[1]), 1);
    pulse(1);
    rd(2'd1, v); chk("R11 turned up", int'(v), 1);

    // R10 fast PWM duty sweep
    wr(2'd0, 8'h21);
    for (int c = 0; c < 258; c += 5) begin
      int cv;
      cv = (c == 255) ? 255 : (c > 255 ? 254 : c);
      if (c == 5) begin
        wr(2'd2, 8'd1);
        repeat (260) @(negedge clk);
        hi = 0;
        repeat (256) begin @(negedge clk); hi += int'(wave_out); end
        chk("R10 fast duty c=1", hi, 2);
      end
      wr(2'd2, 8'(cv));
      repeat (260) @(negedge clk);
      hi = 0;
      repeat (256) begin @(negedge clk); hi += int'(wave_out); end
      chk("R10 fast duty", hi, cv + 1);
    end

    // R11 phase-correct duty sweep
    wr(2'd0, 8'h31);
    for (int k = 0; k < 21; k++) begin
      int cv;
      if (k < 16)       cv = k * 17;
      else if (k == 16) cv = 1;
      else if (k == 17) cv = 2;
      else if (k == 18) cv = 127;
      else if (k == 19) cv = 128;
      else              cv = 254;
      wr(2'd2, 8'(cv));
      repeat (770) @(negedge clk);
      hi = 0;
      repeat (510) begin @(negedge clk); hi += int'(wave_out); end
      chk("R11 phase duty", hi, 2 * cv);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule